// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block sits behind a bit-level ARINC 429 receiver. Each time the front end has gathered a complete 32-bit word, it presents the word with a one-cycle end-of-sequence strobe. The block does three things with that word. It overwrites bit 32 with the result of a parity check. It runs two independently enabled acceptance tests: one against a host-loaded table of labels, and one against a programmed pattern for bits 9 and 10. It pushes every word that passes into a receive FIFO.

The host drains the FIFO over a 16-bit data path. It reads the low half of the oldest word first and the high half second, and the second read removes the word. Three status outputs report the FIFO fill level: not empty, at least half full, and full. The host loads the label table one entry at a time. Each entry carries a valid bit that reset clears.

Top module: `arinc_rx_filter`

## Requirements
- R1: The stored bit 32 (`rx_word[31]`) is 0 when the received 32 bits contain an odd number of ones, and 1 when they contain an even number; bits 1 to 31 are stored unchanged.
- R2: A word is considered only in a cycle where `rx_eos` is high; each strobe adds at most one word to the FIFO, and no word is added without a strobe.
- R3: With `cfg_lbl_en` high, a word is stored only if its label (bits 1 to 8, `rx_word[7:0]`) equals the value of some valid table entry; with `cfg_lbl_en` low, the label has no effect on acceptance.
- R4: With `cfg_bits_en` high, a word is stored only if `rx_word[8]` (bit 9) equals `cfg_match9` and `rx_word[9]` (bit 10) equals `cfg_match10`; with `cfg_bits_en` low, those bits have no effect on acceptance.
- R5: With both filters enabled, a word must pass both to be stored; a word that fails either causes no FIFO write.
- R6: `host_data` shows `rx_word[15:0]` of the oldest word until one `host_rd` pulse, then `rx_word[31:16]`; the next `host_rd` pulse removes that word. A `host_rd` pulse while the FIFO is empty has no effect.
- R7: `data_ready` is high when the FIFO holds at least one word. `half_full` is high when it holds DEPTH/2 (16) or more words. `full` is high when it holds DEPTH (32) words. Words leave in arrival order.
- R8: An accepted word that arrives while the FIFO is full is dropped, and the stored words and their order are unchanged.
- R9: A pulse on `lbl_wr` writes `lbl_wdata` into table entry `lbl_waddr` and marks that entry valid. Reset clears every valid bit and empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | 32 | Received word; bit 1 of the line word is bit 0 |
| rx_eos | input | 1 | One-cycle strobe: `rx_word` holds a complete word |
| cfg_lbl_en | input | 1 | Enable the label-table test |
| cfg_bits_en | input | 1 | Enable the bits 9/10 test |
| cfg_match9 | input | 1 | Required value of bit 9 |
| cfg_match10 | input | 1 | Required value of bit 10 |
| lbl_wr | input | 1 | Label table write strobe |
| lbl_waddr | input | 4 | Label table entry index |
| lbl_wdata | input | 8 | Label value to store |
| host_rd | input | 1 | Host read strobe, one per 16-bit half |
| host_data | output | 16 | Selected half of the oldest word |
| data_ready | output | 1 | FIFO not empty |
| half_full | output | 1 | FIFO holds at least half its depth |
| full | output | 1 | FIFO holds its full depth |

## Verification
The bench builds the block with its default parameters: a 32-word FIFO and a 16-entry label table. A fill of 33 accepted words fits easily inside the run time at this depth. That fill crosses the half-full threshold at exactly 16 words, reaches full at 32, and then exercises the drop-on-full path, after which the whole FIFO is drained and its order checked. A fixed table of words then covers each filter setting alone and the two together, with words that pass and words that fail. A final reset confirms that label entries become invalid, so a word whose label matches stale table contents is not stored.

// File: rtl/arinc_rx_filter.sv
module arinc_rx_filter #(
  parameter int DEPTH = 32,
  parameter int LBL_N = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              rx_word,
  input  logic                     rx_eos,
  input  logic                     cfg_lbl_en,
  input  logic                     cfg_bits_en,
  input  logic                     cfg_match9,
  input  logic                     cfg_match10,
  input  logic                     lbl_wr,
  input  logic [$clog2(LBL_N)-1:0] lbl_waddr,
  input  logic [7:0]               lbl_wdata,
  input  logic                     host_rd,
  output logic [15:0]              host_data,
  output logic                     data_ready,
  output logic                     half_full,
  output logic                     full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [31:0]      mem [DEPTH];
  logic [7:0]       lbl_tab [LBL_N];
  logic [LBL_N-1:0] lbl_vld;
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             rd_hi;
  logic             lbl_hit;

  always_comb begin
    lbl_hit = 1'b0;
    for (int i = 0; i < LBL_N; i++)
      if (lbl_vld[i] && lbl_tab[i] == rx_word[7:0]) lbl_hit = 1'b1;
  end

  wire        bits_ok = !cfg_bits_en ||
                        (rx_word[8] == cfg_match9 && rx_word[9] == cfg_match10);
  wire        accept  = rx_eos && (!cfg_lbl_en || lbl_hit) && bits_ok;
  wire        push    = accept && !full;
  wire        pop     = host_rd && rd_hi && data_ready;
  wire [31:0] stored  = {~(^rx_word), rx_word[30:0]};

  assign data_ready = cnt != '0;
  assign full       = cnt == CW'(DEPTH);
  assign half_full  = cnt >= CW'(DEPTH / 2);
  assign host_data  = rd_hi ? mem[rp][31:16] : mem[rp][15:0];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= stored;
    if (lbl_wr) lbl_tab[lbl_waddr] <= lbl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      rd_hi   <= 1'b0;
      lbl_vld <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
      if (host_rd && data_ready) rd_hi <= ~rd_hi;
      if (lbl_wr) lbl_vld[lbl_waddr] <= 1'b1;
    end
  end

  // R7 count never exceeds depth
  always_comb a_r7_no_overflow: assert (cnt <= CW'(DEPTH));

  a_r2_rise_needs_eos: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(rx_eos));

  a_r2_no_growth_without_eos: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_eos |=> cnt <= $past(cnt));

  a_r6_empty_after_high_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(host_rd && rd_hi));

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !host_rd) |=> full);

  a_r6_half_flips_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && data_ready) |=> rd_hi != $past(rd_hi));
endmodule

// File: tb/arinc_rx_filter_tb_top.sv
module arinc_rx_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_word = '0;
  logic        rx_eos = 1'b0;
  logic        cfg_lbl_en = 1'b0, cfg_bits_en = 1'b0, cfg_match9 = 1'b0, cfg_match10 = 1'b0;
  logic        lbl_wr = 1'b0;
  logic [3:0]  lbl_waddr = '0;
  logic [7:0]  lbl_wdata = '0;
  logic        host_rd = 1'b0;
  logic [15:0] host_data;
  logic        data_ready, half_full, full;
  int          checks = 0, fails = 0;

  always #2 clk = ~clk;

  arinc_rx_filter dut_i (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_eos(rx_eos),
    .cfg_lbl_en(cfg_lbl_en), .cfg_bits_en(cfg_bits_en),
    .cfg_match9(cfg_match9), .cfg_match10(cfg_match10),
    .lbl_wr(lbl_wr), .lbl_waddr(lbl_waddr), .lbl_wdata(lbl_wdata),
    .host_rd(host_rd), .host_data(host_data),
    .data_ready(data_ready), .half_full(half_full), .full(full));

  // {lbl_en, bits_en, match9, match10, keep, word}
  localparam logic [36:0] VEC [10] = '{
    {5'b00001, 32'h0000_0001},
    {5'b00001, 32'h8000_0003},
    {5'b00001, 32'h0000_0003},
    {5'b10001, 32'h1234_5631},
    {5'b10000, 32'h1234_5632},
    {5'b01101, 32'h0000_0100},
    {5'b01100, 32'h0000_0300},
    {5'b11101, 32'h0000_01A7},
    {5'b11100, 32'h0000_03A7},
    {5'b11000, 32'h0000_0032}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expw(input logic [31:0] w);
    return {~(^w), w[30:0]};
  endfunction

  task automatic send(input logic [31:0] w);
    rx_word = w; rx_eos = 1'b1;
    @(negedge clk); rx_eos = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] w);
    w[15:0] = host_data;
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
    w[31:16] = host_data;
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wr_lbl(input logic [3:0] a, input logic [7:0] d);
    lbl_waddr = a; lbl_wdata = d; lbl_wr = 1'b1;
    @(negedge clk); lbl_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] got;
    string req;
    do_reset();
    chk(!data_ready && !half_full && !full, "R9", {data_ready, half_full, full}, 0);

    wr_lbl(4'd2, 8'h31);
    wr_lbl(4'd9, 8'hA7);

    for (int i = 0; i < 10; i++) begin
      cfg_lbl_en = VEC[i][36]; cfg_bits_en = VEC[i][35];
      cfg_match9 = VEC[i][34]; cfg_match10 = VEC[i][33];
      req = (VEC[i][36] && VEC[i][35]) ? "R5" : VEC[i][36] ? "R3" : VEC[i][35] ? "R4" : "R1";
      send(VEC[i][31:0]);
      if (VEC[i][32]) begin
        chk(data_ready, req, data_ready, 1);
        read_word(got);
        chk(got == expw(VEC[i][31:0]), req, got, expw(VEC[i][31:0]));
      end
      chk(!data_ready, req, data_ready, 0);
    end

    // R2: no strobe, no write
    cfg_lbl_en = 0; cfg_bits_en = 0;
    rx_word = 32'hFFFF_FFFF; repeat (3) @(negedge clk);
    chk(!data_ready, "R2", data_ready, 0);

    // R6: read on empty ignored, then low half first
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
    send(32'h0ABC_1234);
    chk(host_data == 16'h1234, "R6", host_data, 16'h1234);
    read_word(got);
    chk(got == expw(32'h0ABC_1234), "R6", got, expw(32'h0ABC_1234));

    // R7 and R8: fill, overflow, drain
    for (int i = 0; i < 33; i++) begin
      send(32'h0001_0000 * i + i);
      if (i == 14) chk(!half_full, "R7", half_full, 0);
      if (i == 15) chk(half_full && !full, "R7", {half_full, full}, 2);
      if (i == 30) chk(!full, "R7", full, 0);
      if (i == 31) chk(full, "R7", full, 1);
    end
    chk(full, "R8", full, 1);
    for (int i = 0; i < 32; i++) begin
      read_word(got);
      chk(got == expw(32'h0001_0000 * i + i), "R8", got, expw(32'h0001_0000 * i + i));
    end
    chk(!data_ready, "R7", data_ready, 0);

    // R9: reset clears label validity
    do_reset();
    cfg_lbl_en = 1'b1;
    send(32'h0000_0031);
    chk(!data_ready, "R9", data_ready, 0);
    wr_lbl(4'd5, 8'h31);
    send(32'h0000_0031);
    chk(data_ready, "R9", data_ready, 1);
    read_word(got);
    chk(got == expw(32'h0000_0031), "R9", got, expw(32'h0000_0031));

    summary();
  end
endmodule